// File: doc/BRIEF.md
# Processor Address Disposition Decoder

This block decides where each processor-originated request goes. For every request it looks at the 40-bit physical address, whether the access is a read or a write, and whether the transaction is an interrupt message or an ordinary memory access. From these it produces one routing target. The possible targets are coherent main memory, non-coherent main memory, a PCI Express port (with its index), the configuration-access path, the internal register space, the processor interrupt bus, or the downstream legacy hub link. A hub-link request is sent either as an ordinary request or flagged so that it is master aborted.

Software-loaded inputs set the region boundaries. These are the top of low memory, the base of the 256 MB configuration window, the limit of high memory, a 2-bit attribute for the legacy shadow segment, a selector for the I/O interrupt-controller window, and, for each of four ports, a memory window and a prefetchable window. Overlapping regions are resolved by a fixed priority. The configuration window comes first. Next is the fixed region from FE00_0000h to FFFF_FFFFh, then the memory ranges, then the port windows. Whatever is left falls through to a subtractive default.

The request side and the result side each use a valid/ready handshake, with a one-entry output slot between them. The slot is a two-state machine. In state ST_EMPTY, the LOAD transition moves to ST_FULL when a request is accepted. In state ST_FULL, one of three transitions applies: WAIT keeps the slot while `rsp_ready` is low, REFILL replaces the result when the consumer takes it and a new request arrives in the same cycle, and DRAIN returns to ST_EMPTY when the result is taken and no request arrives.

Top module: `proc_addr_router`

## Requirements
- R1: `req_ready` is high when the slot is empty or `rsp_ready` is high. A request accepted at a clock edge shows its result with `rsp_valid` high right after that edge. After reset, `rsp_valid` is low and `req_ready` is high. Target codes are: 0 coherent memory, 1 non-coherent memory, 2 PCI Express port, 3 configuration access, 4 internal registers, 5 interrupt bus, 6 hub link, 7 hub link with master abort. `rsp_port` is 0 unless the code is 2.
- R2: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_target` and `rsp_port` hold their values.
- R3: Addresses 0E0000h–0FFFFFh use `cfg_shadow_attr`. Bit 1 set sends writes to memory, and bit 0 set sends reads to memory. A memory-bound access here is non-coherent (code 1). Otherwise it goes to the hub link (code 6).
- R4: Addresses from 10_0000h up to, but not including, `cfg_tolm` are coherent memory (code 0).
- R5: Addresses in [`cfg_ecfg_base`, `cfg_ecfg_base` + 256 MB) give code 3. This takes priority over every other region, including memory.
- R6: Addresses from `cfg_tolm` up to FE00_0000h go to the lowest-numbered port whose memory window or prefetchable window contains them. Both windows include their base and their limit. If no window matches, the result is code 7.
- R7: In FE00_0000h–FEBF_FFFFh, an offset from FE00_0000h below REG_SPAN (64 KB by default) gives code 4. Any other offset in this range gives code 7.
- R8: In FEC0_0000h–FEC8_FFFFh, the result is the port given by `cfg_ioapic_port` (code 2). If `cfg_ioapic_to_hub` is high, the result is code 6 instead.
- R9: In FEE0_0000h–FEEF_FFFFh, an interrupt transaction gives code 5 and a memory transaction gives code 7. Code 5 never results from a memory transaction.
- R10: FEC9_0000h–FED1_FFFFh, FF00_0000h–FFFF_FFFFh and the other unlisted addresses in FE00_0000h–FFFF_FFFFh give code 6. So do addresses below 0E0000h that no window claims.
- R11: Addresses from 1_0000_0000h up to and including `cfg_himem_limit` are coherent memory (code 0). An address at or above 4 GB never gives code 1, 4 or 5.
- R12: Addresses above 4 GB that no memory range claims go to the lowest-numbered port whose window contains them. If none does, the result is code 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 40 | Physical address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_intr | input | 1 | 1 = interrupt transaction |
| cfg_tolm | input | 40 | Top of low memory (exclusive) |
| cfg_ecfg_base | input | 40 | Configuration window base |
| cfg_himem_limit | input | 40 | High memory limit (inclusive) |
| cfg_shadow_attr | input | 2 | Shadow segment attribute |
| cfg_mmio_base | input | 160 | Per-port memory window base, port p at bits [40p+39:40p] |
| cfg_mmio_limit | input | 160 | Per-port memory window limit |
| cfg_pf_base | input | 160 | Per-port prefetchable window base |
| cfg_pf_limit | input | 160 | Per-port prefetchable window limit |
| cfg_ioapic_port | input | 2 | Port that serves the interrupt-controller window |
| cfg_ioapic_to_hub | input | 1 | Send the interrupt-controller window to the hub link |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result consumed |
| rsp_target | output | 3 | Target code |
| rsp_port | output | 2 | Port index when the target is a port |

## Verification
On every cycle, the assertions check the slot's behaviour. An accepted request must appear as a result one edge later, and a stalled result must stay unchanged. They also check two routing limits: a memory transaction can never reach the interrupt bus, and addresses above 4 GB can never reach the shadow, register or interrupt targets. The exact route for each region cannot be shown by these properties. That includes the edges of each region, the four shadow attribute codes, overlapping windows, and the priority of the configuration window over memory. The bench scenarios cover these, and they run with and without back-pressure from the result side.

// File: rtl/apd_pkg.sv
`timescale 1ns/1ps
package apd_pkg;

    typedef enum logic [2:0] {
        TGT_MEM_COH   = 3'd0,
        TGT_MEM_NC    = 3'd1,
        TGT_PCIE      = 3'd2,
        TGT_CFG       = 3'd3,
        TGT_INTREG    = 3'd4,
        TGT_INTBUS    = 3'd5,
        TGT_HUB       = 3'd6,
        TGT_HUB_ABORT = 3'd7
    } tgt_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } slot_state_e;

endpackage

// File: rtl/apd_window_bank.sv
`timescale 1ns/1ps
module apd_window_bank #(
    parameter int ADDR_W = 40,
    parameter int NPORT  = 4,
    parameter int PORT_W = 2
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [NPORT*ADDR_W-1:0] mmio_base,
    input  logic [NPORT*ADDR_W-1:0] mmio_limit,
    input  logic [NPORT*ADDR_W-1:0] pf_base,
    input  logic [NPORT*ADDR_W-1:0] pf_limit,
    output logic                    hit,
    output logic [PORT_W-1:0]       port
);

    logic [NPORT-1:0] port_hit;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            logic [ADDR_W-1:0] mb, ml, pb, pl;
            logic              in_mmio, in_pf;
            assign mb = mmio_base [p*ADDR_W +: ADDR_W];
            assign ml = mmio_limit[p*ADDR_W +: ADDR_W];
            assign pb = pf_base   [p*ADDR_W +: ADDR_W];
            assign pl = pf_limit  [p*ADDR_W +: ADDR_W];
            assign in_mmio = (addr >= mb) && (addr <= ml);
            assign in_pf   = (addr >= pb) && (addr <= pl);
            assign port_hit[p] = in_mmio || in_pf;
        end
    endgenerate

    // lowest-numbered matching port wins
    always_comb begin
        hit  = |port_hit;
        port = '0;
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (port_hit[p]) begin
                port = PORT_W'(p);
            end
        end
    end

endmodule

// File: rtl/apd_mem_decode.sv
`timescale 1ns/1ps
module apd_mem_decode #(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic [1:0]        shadow_attr,
    input  logic [ADDR_W-1:0] tolm,
    input  logic [ADDR_W-1:0] himem_limit,
    output logic              hit,
    output apd_pkg::tgt_e     tgt
);
    import apd_pkg::*;

    localparam logic [ADDR_W-1:0] SHADOW_LO = ADDR_W'(64'h0_000E_0000);
    localparam logic [ADDR_W-1:0] SHADOW_HI = ADDR_W'(64'h0_000F_FFFF);
    localparam logic [ADDR_W-1:0] LOWMEM_LO = ADDR_W'(64'h0_0010_0000);
    localparam logic [ADDR_W-1:0] HIMEM_LO  = ADDR_W'(64'h1_0000_0000);

    logic in_shadow, in_low, in_high, shadow_to_mem;

    assign in_shadow = (addr >= SHADOW_LO) && (addr <= SHADOW_HI);
    assign in_low    = (addr >= LOWMEM_LO) && (addr < tolm);
    assign in_high   = (addr >= HIMEM_LO)  && (addr <= himem_limit);
    // bit 1 enables memory for writes, bit 0 for reads
    assign shadow_to_mem = write ? shadow_attr[1] : shadow_attr[0];

    always_comb begin
        hit = 1'b1;
        tgt = TGT_HUB;
        if (in_shadow) begin
            tgt = shadow_to_mem ? TGT_MEM_NC : TGT_HUB;
        end else if (in_low || in_high) begin
            tgt = TGT_MEM_COH;
        end else begin
            hit = 1'b0;
        end
    end

endmodule

// File: rtl/apd_fixed_decode.sv
`timescale 1ns/1ps
module apd_fixed_decode #(
    parameter int          ADDR_W   = 40,
    parameter int          PORT_W   = 2,
    parameter int unsigned REG_SPAN = 32'h0001_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              intr,
    input  logic [PORT_W-1:0] ioapic_port,
    input  logic              ioapic_to_hub,
    output logic              hit,
    output apd_pkg::tgt_e     tgt,
    output logic [PORT_W-1:0] port
);
    import apd_pkg::*;

    localparam logic [ADDR_W-1:0] FIX_LO    = ADDR_W'(64'hFE00_0000);
    localparam logic [ADDR_W-1:0] FIX_HI    = ADDR_W'(64'hFFFF_FFFF);
    localparam logic [ADDR_W-1:0] REGS_HI   = ADDR_W'(64'hFEBF_FFFF);
    localparam logic [ADDR_W-1:0] IOAPIC_LO = ADDR_W'(64'hFEC0_0000);
    localparam logic [ADDR_W-1:0] IOAPIC_HI = ADDR_W'(64'hFEC8_FFFF);
    localparam logic [ADDR_W-1:0] INTR_LO   = ADDR_W'(64'hFEE0_0000);
    localparam logic [ADDR_W-1:0] INTR_HI   = ADDR_W'(64'hFEEF_FFFF);
    localparam logic [ADDR_W-1:0] REG_SPAN_A = ADDR_W'(REG_SPAN);

    logic [ADDR_W-1:0] reg_offset;
    logic in_regs, in_ioapic, in_intr;

    assign hit        = (addr >= FIX_LO) && (addr <= FIX_HI);
    assign reg_offset = addr - FIX_LO;
    assign in_regs    = hit && (addr <= REGS_HI);
    assign in_ioapic  = (addr >= IOAPIC_LO) && (addr <= IOAPIC_HI);
    assign in_intr    = (addr >= INTR_LO) && (addr <= INTR_HI);

    always_comb begin
        tgt  = TGT_HUB;
        port = '0;
        if (in_regs) begin
            tgt = (reg_offset < REG_SPAN_A) ? TGT_INTREG : TGT_HUB_ABORT;
        end else if (in_ioapic) begin
            if (!ioapic_to_hub) begin
                tgt  = TGT_PCIE;
                port = ioapic_port;
            end
        end else if (in_intr) begin
            tgt = intr ? TGT_INTBUS : TGT_HUB_ABORT;
        end
    end

endmodule

// File: rtl/proc_addr_router.sv
`timescale 1ns/1ps
module proc_addr_router #(
    parameter int          ADDR_W        = 40,
    parameter int          NPORT         = 4,
    parameter int          PORT_W        = 2,
    parameter int          CFG_SPAN_LOG2 = 28,
    parameter int unsigned REG_SPAN      = 32'h0001_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_write,
    input  logic                    req_intr,
    input  logic [ADDR_W-1:0]       cfg_tolm,
    input  logic [ADDR_W-1:0]       cfg_ecfg_base,
    input  logic [ADDR_W-1:0]       cfg_himem_limit,
    input  logic [1:0]              cfg_shadow_attr,
    input  logic [NPORT*ADDR_W-1:0] cfg_mmio_base,
    input  logic [NPORT*ADDR_W-1:0] cfg_mmio_limit,
    input  logic [NPORT*ADDR_W-1:0] cfg_pf_base,
    input  logic [NPORT*ADDR_W-1:0] cfg_pf_limit,
    input  logic [PORT_W-1:0]       cfg_ioapic_port,
    input  logic                    cfg_ioapic_to_hub,
    output logic                    rsp_valid,
    input  logic                    rsp_ready,
    output logic [2:0]              rsp_target,
    output logic [PORT_W-1:0]       rsp_port
);
    import apd_pkg::*;

    localparam logic [ADDR_W:0]   CFG_SPAN  = (ADDR_W+1)'(1) << CFG_SPAN_LOG2;
    localparam logic [ADDR_W-1:0] FOUR_GB   = ADDR_W'(64'h1_0000_0000);

    // ---------------- region decoders ----------------
    logic              fix_hit, mem_hit, win_hit;
    tgt_e              fix_tgt, mem_tgt;
    logic [PORT_W-1:0] fix_port, win_port;

    apd_fixed_decode #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .REG_SPAN(REG_SPAN)) u_fixed (
        .addr(req_addr), .intr(req_intr), .ioapic_port(cfg_ioapic_port),
        .ioapic_to_hub(cfg_ioapic_to_hub), .hit(fix_hit), .tgt(fix_tgt), .port(fix_port)
    );

    apd_mem_decode #(.ADDR_W(ADDR_W)) u_mem (
        .addr(req_addr), .write(req_write), .shadow_attr(cfg_shadow_attr),
        .tolm(cfg_tolm), .himem_limit(cfg_himem_limit), .hit(mem_hit), .tgt(mem_tgt)
    );

    apd_window_bank #(.ADDR_W(ADDR_W), .NPORT(NPORT), .PORT_W(PORT_W)) u_win (
        .addr(req_addr), .mmio_base(cfg_mmio_base), .mmio_limit(cfg_mmio_limit),
        .pf_base(cfg_pf_base), .pf_limit(cfg_pf_limit), .hit(win_hit), .port(win_port)
    );

    logic in_cfg, in_low_mmio;
    assign in_cfg      = (req_addr >= cfg_ecfg_base) &&
                         ({1'b0, req_addr} < ({1'b0, cfg_ecfg_base} + CFG_SPAN));
    assign in_low_mmio = (req_addr >= cfg_tolm) && (req_addr < FOUR_GB);

    // fixed priority merge
    tgt_e              dec_tgt;
    logic [PORT_W-1:0] dec_port;
    always_comb begin
        dec_port = '0;
        if (in_cfg) begin
            dec_tgt = TGT_CFG;
        end else if (fix_hit) begin
            dec_tgt  = fix_tgt;
            dec_port = fix_port;
        end else if (mem_hit) begin
            dec_tgt = mem_tgt;
        end else if (win_hit) begin
            dec_tgt  = TGT_PCIE;
            dec_port = win_port;
        end else if (in_low_mmio) begin
            dec_tgt = TGT_HUB_ABORT;
        end else begin
            dec_tgt = TGT_HUB;
        end
    end

    // ---------------- output slot state machine ----------------
    slot_state_e state_q, state_d;
    logic        accept;

    assign req_ready = (state_q == ST_EMPTY) || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (req_valid)                state_d = ST_FULL;   // LOAD
            ST_FULL:  if (rsp_ready && !req_valid)  state_d = ST_EMPTY;  // DRAIN
                      // REFILL and WAIT stay in ST_FULL
            default:                                state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    tgt_e              tgt_q;
    logic [PORT_W-1:0] port_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q  <= TGT_HUB;
            port_q <= '0;
        end else if (accept) begin
            tgt_q  <= dec_tgt;
            port_q <= dec_port;
        end
    end

    assign rsp_valid  = (state_q == ST_FULL);
    assign rsp_target = tgt_q;
    assign rsp_port   = port_q;

    // ---------------- assertions ----------------
    assert_result_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);

    assert_hold_while_stalled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_target) && $stable(rsp_port)));

    assert_intbus_needs_intr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_intr) |=> (rsp_target != 3'(TGT_INTBUS)));

    assert_upper_space_targets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_addr >= FOUR_GB) && !in_cfg) |=>
        ((rsp_target != 3'(TGT_MEM_NC)) && (rsp_target != 3'(TGT_INTREG)) &&
         (rsp_target != 3'(TGT_INTBUS))));

endmodule

// File: tb/proc_addr_router_bench.sv
`timescale 1ns/1ps
module proc_addr_router_bench;

    localparam logic [2:0] T_COH = 3'd0, T_NC = 3'd1, T_PCIE = 3'd2, T_CFG = 3'd3,
                           T_REG = 3'd4, T_INTB = 3'd5, T_HUB = 3'd6, T_ABT = 3'd7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0, req_intr = 1'b0;
    logic [39:0]  req_addr = '0;
    logic         req_ready;
    logic [39:0]  cfg_tolm, cfg_ecfg_base, cfg_himem_limit;
    logic [1:0]   cfg_shadow_attr;
    logic [159:0] cfg_mmio_base, cfg_mmio_limit, cfg_pf_base, cfg_pf_limit;
    logic [1:0]   cfg_ioapic_port;
    logic         cfg_ioapic_to_hub;
    logic         rsp_valid;
    logic         rsp_ready = 1'b1;
    logic [2:0]   rsp_target;
    logic [1:0]   rsp_port;

    int checks = 0, errors = 0;
    bit stall_en = 1'b0, finished = 1'b0;
    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    proc_addr_router u_proc_addr_router (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_intr(req_intr),
        .cfg_tolm(cfg_tolm), .cfg_ecfg_base(cfg_ecfg_base), .cfg_himem_limit(cfg_himem_limit),
        .cfg_shadow_attr(cfg_shadow_attr), .cfg_mmio_base(cfg_mmio_base),
        .cfg_mmio_limit(cfg_mmio_limit), .cfg_pf_base(cfg_pf_base), .cfg_pf_limit(cfg_pf_limit),
        .cfg_ioapic_port(cfg_ioapic_port), .cfg_ioapic_to_hub(cfg_ioapic_to_hub),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_target(rsp_target), .rsp_port(rsp_port)
    );

    // result-side back-pressure pattern
    int cyc = 0;
    always @(posedge clk) begin
        #1;
        cyc++;
        rsp_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
    end

    // monitor / scoreboard
    logic       prev_stall = 1'b0;
    logic [2:0] prev_t = '0;
    logic [1:0] prev_p = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                checks++;
                if (!rsp_valid || rsp_target !== prev_t || rsp_port !== prev_p) begin
                    errors++;
                    $display("FAIL R2 hold: got v=%0b t=%0d p=%0d expected v=1 t=%0d p=%0d",
                             rsp_valid, rsp_target, rsp_port, prev_t, prev_p);
                end
            end
            prev_stall = rsp_valid && !rsp_ready;
            prev_t = rsp_target;
            prev_p = rsp_port;
            if (rsp_valid && rsp_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R1 unexpected result t=%0d p=%0d expected none", rsp_target, rsp_port);
                end else begin
                    logic [4:0] e;
                    string tg;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    if ({rsp_target, rsp_port} !== e) begin
                        errors++;
                        $display("FAIL %s: got t=%0d p=%0d expected t=%0d p=%0d",
                                 tg, rsp_target, rsp_port, e[4:2], e[1:0]);
                    end
                end
            end
        end
    end

    task automatic send(input logic [39:0] a, input logic w, input logic irq,
                        input logic [2:0] et, input logic [1:0] ep, input string tag);
        req_addr = a; req_write = w; req_intr = irq; req_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (req_ready) break;
            @(posedge clk); #1;
        end
        exp_q.push_back({et, ep});
        tag_q.push_back(tag);
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b1) begin
            errors++;
            $display("FAIL R1 latency: rsp_valid=%0b expected 1", rsp_valid);
        end
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL R1 watchdog expired, expected completion");
        finish_run();
    end

    task automatic run_set(input bit stall);
        stall_en = stall;
        cfg_shadow_attr = 2'b11;
        send(40'h00_000E_0000, 1'b0, 1'b0, T_NC,  2'd0, "R3 attr11 read");
        send(40'h00_000F_FFFF, 1'b1, 1'b0, T_NC,  2'd0, "R3 attr11 write");
        cfg_shadow_attr = 2'b10;
        send(40'h00_000E_8000, 1'b0, 1'b0, T_HUB, 2'd0, "R3 attr10 read");
        send(40'h00_000E_8000, 1'b1, 1'b0, T_NC,  2'd0, "R3 attr10 write");
        cfg_shadow_attr = 2'b01;
        send(40'h00_000F_0000, 1'b0, 1'b0, T_NC,  2'd0, "R3 attr01 read");
        send(40'h00_000F_0000, 1'b1, 1'b0, T_HUB, 2'd0, "R3 attr01 write");
        cfg_shadow_attr = 2'b00;
        send(40'h00_000F_0000, 1'b0, 1'b0, T_HUB, 2'd0, "R3 attr00 read");
        send(40'h00_000E_0000, 1'b1, 1'b0, T_HUB, 2'd0, "R3 attr00 write");
        send(40'h00_000D_FFFF, 1'b0, 1'b0, T_HUB, 2'd0, "R10 below shadow");
        send(40'h00_0010_0000, 1'b0, 1'b0, T_COH, 2'd0, "R4 low mem start");
        send(40'h00_7FFF_FFFF, 1'b1, 1'b0, T_COH, 2'd0, "R4 below tolm");
        send(40'h00_8000_0000, 1'b0, 1'b0, T_PCIE, 2'd0, "R6 tolm port0");
        send(40'h00_9000_0010, 1'b0, 1'b0, T_PCIE, 2'd1, "R6 port1");
        send(40'h00_C090_0000, 1'b0, 1'b0, T_PCIE, 2'd2, "R6 overlap lowest port");
        send(40'h00_A000_0005, 1'b1, 1'b0, T_PCIE, 2'd3, "R6 low prefetch port3");
        send(40'h00_B000_0000, 1'b0, 1'b0, T_ABT, 2'd0, "R6 no window");
        send(40'h00_FDFF_FFFF, 1'b0, 1'b0, T_ABT, 2'd0, "R6 top of mmio");
        send(40'h00_E000_0000, 1'b0, 1'b0, T_CFG, 2'd0, "R5 cfg base");
        send(40'h00_EFFF_FFFF, 1'b1, 1'b0, T_CFG, 2'd0, "R5 cfg last");
        send(40'h00_F000_0000, 1'b0, 1'b0, T_ABT, 2'd0, "R5 past cfg window");
        send(40'h00_FE00_8000, 1'b0, 1'b0, T_REG, 2'd0, "R7 valid offset");
        send(40'h00_FE01_0000, 1'b0, 1'b0, T_ABT, 2'd0, "R7 invalid offset");
        send(40'h00_FEBF_FFFF, 1'b1, 1'b0, T_ABT, 2'd0, "R7 range end");
        cfg_ioapic_to_hub = 1'b0;
        send(40'h00_FEC4_0000, 1'b0, 1'b0, T_PCIE, 2'd2, "R8 selected port");
        cfg_ioapic_to_hub = 1'b1;
        send(40'h00_FEC8_FFFF, 1'b0, 1'b0, T_HUB, 2'd0, "R8 to hub");
        send(40'h00_FEE0_0000, 1'b1, 1'b1, T_INTB, 2'd0, "R9 interrupt");
        send(40'h00_FEEF_FFFF, 1'b1, 1'b0, T_ABT, 2'd0, "R9 memory in intr range");
        send(40'h00_FEC9_0000, 1'b0, 1'b0, T_HUB, 2'd0, "R10 timers start");
        send(40'h00_FED1_FFFF, 1'b0, 1'b0, T_HUB, 2'd0, "R10 timers end");
        send(40'h00_FEDA_0000, 1'b0, 1'b0, T_HUB, 2'd0, "R10 unlisted hole");
        send(40'h00_FF00_0000, 1'b0, 1'b0, T_HUB, 2'd0, "R10 firmware");
        send(40'h00_FFFF_FFFF, 1'b0, 1'b0, T_HUB, 2'd0, "R10 firmware end");
        send(40'h01_0000_0000, 1'b0, 1'b0, T_COH, 2'd0, "R11 4GB");
        send(40'h01_7FFF_FFFF, 1'b1, 1'b0, T_COH, 2'd0, "R11 limit inclusive");
        send(40'h01_8000_0000, 1'b0, 1'b0, T_HUB, 2'd0, "R12 above himem");
        send(40'h20_0000_0000, 1'b0, 1'b0, T_PCIE, 2'd1, "R12 prefetch base");
        send(40'h20_FFFF_FFFF, 1'b1, 1'b0, T_PCIE, 2'd1, "R12 prefetch limit");
        send(40'h21_0000_0000, 1'b0, 1'b0, T_HUB, 2'd0, "R12 past prefetch");
        send(40'hFF_FFFF_FFFF, 1'b0, 1'b0, T_HUB, 2'd0, "R12 top address");
        cfg_ecfg_base = 40'h00_4000_0000;
        send(40'h00_4000_1000, 1'b0, 1'b0, T_CFG, 2'd0, "R5 cfg over memory");
        cfg_ecfg_base = 40'h00_E000_0000;
    endtask

    initial begin
        cfg_tolm        = 40'h00_8000_0000;
        cfg_ecfg_base   = 40'h00_E000_0000;
        cfg_himem_limit = 40'h01_7FFF_FFFF;
        cfg_shadow_attr = 2'b11;
        cfg_ioapic_port = 2'd2;
        cfg_ioapic_to_hub = 1'b0;
        cfg_mmio_base  = {40'h00_C080_0000, 40'h00_C000_0000, 40'h00_9000_0000, 40'h00_8000_0000};
        cfg_mmio_limit = {40'h00_C0FF_FFFF, 40'h00_C0FF_FFFF, 40'h00_9FFF_FFFF, 40'h00_8FFF_FFFF};
        cfg_pf_base    = {40'h00_A000_0000, 40'hFF_FFFF_FFFF, 40'h20_0000_0000, 40'hFF_FFFF_FFFF};
        cfg_pf_limit   = {40'h00_A0FF_FFFF, 40'h00_0000_0000, 40'h20_FFFF_FFFF, 40'h00_0000_0000};

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset: rsp_valid=%0b req_ready=%0b expected 0 and 1", rsp_valid, req_ready);
        end
        @(posedge clk); #1;

        run_set(1'b0);
        run_set(1'b1);

        stall_en = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1 results missing: %0d left expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule